// File: doc/BRIEF.md
# DDR Read Capture Window Controller

This block governs how read data from a DDR SDRAM interface with nine byte lanes is gathered and merged. Once a read command is accepted, the block counts half-clock ticks. Each lane may then accept its first strobe edge only inside a short window. A lane stores up to four data beats as its own strobes arrive. The lanes do not depend on each other, so skew between them is absorbed. At a programmed read-out point, all lanes are copied together into one aligned burst, which goes to the downstream data buffer with a single valid pulse.

The block clock is the tick clock. One memory clock equals two ticks, which gives the half-cycle resolution. Three configuration fields set the timing, and all three are sampled when the command is accepted:

- a whole-cycle delay `cas_whole` (W);
- a half-cycle adder `cas_half` (H);
- a read-out delay `fifo_dly` (F).

A lane whose first strobe edge misses the window is flagged in a per-lane error vector. Its data is still delivered.

Tick k is the clock cycle that follows the k-th rising edge after the edge that accepted the command. The window opens at tick T = 2W + H. Read-out takes place at the edge that ends tick R = T + 3 + 2F.

Top module: `ddr_rd_capture`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_err` are all zero.
- R2: A `rd_cmd` seen while idle is accepted and snapshots W, H and F. `busy` is high from the following cycle through tick R and low afterwards.
- R3: While `busy` is high, `rd_cmd` and changes to the configuration inputs are ignored. Timing, data and flags of the burst in flight are unaffected.
- R4: The acceptance window covers ticks T and T+1, where T = 2W + H. A lane whose first strobe edge falls in one of these two ticks gets no error flag.
- R5: A lane gets its error flag if its first strobe edge falls before tick T or after tick T+1, or if it has no strobe edge before read-out. Its captured beats are still delivered.
- R6: Each lane stores `dq` bytes in beat order on its own strobe edges (`dqs_edge` high in a tick), up to tick R-1. Edges beyond the fourth are ignored.
- R7: `out_valid` is high for exactly one cycle, the cycle after tick R, with R = T + 3 + 2F. It is low at all other times.
- R8: In `out_data`, beat b of lane l sits at bits [(9b + l)*8 +: 8]. Lane 0 occupies the low byte of each beat, and beat 0 is the lowest beat. Beats not received read as zero.
- R9: `out_err` holds bit l = lane l error while `out_valid` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (two ticks per memory clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Read command issue pulse |
| cas_whole | input | 3 | Whole-cycle window delay W |
| cas_half | input | 1 | Half-cycle adder H |
| fifo_dly | input | 2 | Read-out delay F in memory cycles |
| dqs_edge | input | 9 | Per-lane strobe edge seen in this tick |
| dq | input | 72 | Per-lane data byte, lane l at [8l +: 8] |
| busy | output | 1 | Burst in flight |
| out_valid | output | 1 | One-cycle pulse with the aligned burst |
| out_data | output | 288 | Four beats of nine lane bytes |
| out_err | output | 9 | Per-lane window error flags |

## Verification
The hardest state to reach from the ports is a burst where lanes disagree. In such a burst some lanes open early, some late and some not at all, and others strobe more than four times. All of this is combined with a late read-out setting and with a second command and changed configuration arriving mid-flight. The stimulus draws a first-edge tick for every lane independently from one tick before the window to one tick after it, together with a random edge count from zero to six. Directed bursts then pin each of these edge placements, including the half-cycle window offset.

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture #(
  parameter int LANES = 9,
  parameter int BEATS = 4,
  parameter int WW    = 3,
  parameter int FW    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_cmd,
  input  logic [WW-1:0]            cas_whole,
  input  logic                     cas_half,
  input  logic [FW-1:0]            fifo_dly,
  input  logic [LANES-1:0]         dqs_edge,
  input  logic [LANES*8-1:0]       dq,
  output logic                     busy,
  output logic                     out_valid,
  output logic [BEATS*LANES*8-1:0] out_data,
  output logic [LANES-1:0]         out_err
);
  localparam int DW  = BEATS * LANES * 8;
  localparam int CW  = $clog2(2 * (2**WW) + 2 * (2**FW) + 8);
  localparam int BCW = $clog2(BEATS + 1);

  logic [CW-1:0]  cnt, t_open, t_read;
  logic [DW-1:0]  lat;
  logic [BCW-1:0] bc [LANES];
  logic [LANES-1:0] err, fin_err;

  wire in_win = (cnt == t_open) || (cnt == t_open + CW'(1));
  wire rd_now = busy && (cnt == t_read);

  always_comb
    for (int l = 0; l < LANES; l++)
      fin_err[l] = err[l] | (bc[l] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_err   <= '0;
      out_data  <= '0;
      cnt       <= '0;
      t_open    <= '0;
      t_read    <= '0;
      lat       <= '0;
      err       <= '0;
      for (int l = 0; l < LANES; l++) bc[l] <= '0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= '0;
      if (!busy) begin
        if (rd_cmd) begin
          busy   <= 1'b1;
          cnt    <= CW'(1);
          t_open <= CW'({cas_whole, cas_half});
          t_read <= CW'({cas_whole, cas_half}) + CW'(3) + CW'({fifo_dly, 1'b0});
          lat    <= '0;
          err    <= '0;
          for (int l = 0; l < LANES; l++) bc[l] <= '0;
        end
      end else begin
        cnt <= cnt + CW'(1);
        for (int l = 0; l < LANES; l++)
          if (dqs_edge[l] && bc[l] < BCW'(BEATS)) begin
            lat[(int'(bc[l]) * LANES + l) * 8 +: 8] <= dq[l*8 +: 8];
            bc[l] <= bc[l] + BCW'(1);
            if (bc[l] == '0 && !in_win) err[l] <= 1'b1;
          end
        if (rd_now) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= lat;
          out_err   <= fin_err;
        end
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy && $past(busy)); // R2
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rd_cmd)); // R3
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err != '0) |-> out_valid); // R9
endmodule

// File: tb/ddr_rd_capture_test.sv
module ddr_rd_capture_test;
  localparam int L  = 9;
  localparam int B  = 4;
  localparam int DW = B * L * 8;

  logic clk = 1'b0, rst_n = 1'b0, rd_cmd = 1'b0, cas_half = 1'b0;
  logic [2:0] cas_whole = '0;
  logic [1:0] fifo_dly = '0;
  logic [L-1:0] dqs_edge = '0;
  logic [L*8-1:0] dq = '0;
  logic busy, out_valid;
  logic [DW-1:0] out_data;
  logic [L-1:0] out_err;

  int checks = 0, fails = 0;
  logic [L*8-1:0] dqv [0:40];
  int s_t [L];
  int n_e [L];

  always #4 clk = ~clk;

  ddr_rd_capture uut (.clk, .rst_n, .rd_cmd, .cas_whole, .cas_half, .fifo_dly,
                      .dqs_edge, .dq, .busy, .out_valid, .out_data, .out_err);

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_data(int r);
    logic [DW-1:0] d = '0;
    for (int l = 0; l < L; l++)
      for (int b = 0; b < B; b++)
        if (b < n_e[l] && s_t[l] + b <= r - 1)
          d[(b * L + l) * 8 +: 8] = dqv[s_t[l] + b][l*8 +: 8];
    return d;
  endfunction

  function automatic logic [L-1:0] exp_err(int t);
    logic [L-1:0] e;
    for (int l = 0; l < L; l++)
      e[l] = (n_e[l] == 0) || (s_t[l] != t && s_t[l] != t + 1);
    return e;
  endfunction

  // mode: 0 random, 1 all at T, 2 all at T+1, 3 lane0 early / lane1 late,
  //       4 lane8 silent, 5 six edges per lane
  task automatic burst(int w, int h, int f, int mode, bit interfere);
    int t = 2 * w + h;
    int r = t + 3 + 2 * f;
    bit quiet = 1'b1;
    for (int l = 0; l < L; l++) begin
      n_e[l] = 4;
      s_t[l] = t;
      case (mode)
        0: begin
          s_t[l] = t - 1 + int'($urandom_range(0, 3));
          n_e[l] = int'($urandom_range(0, 6));
        end
        2: s_t[l] = t + 1;
        3: if (l == 0) s_t[l] = t - 1; else if (l == 1) s_t[l] = t + 2;
        4: if (l == 8) n_e[l] = 0;
        5: n_e[l] = 6;
        default: ;
      endcase
    end
    cas_whole = 3'(w); cas_half = 1'(h); fifo_dly = 2'(f); rd_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_cmd = 1'b0;
    check("R2 busy after command", DW'(busy), DW'(1));
    for (int k = 1; k <= r; k++) begin
      dqv[k] = {$urandom, $urandom, $urandom};
      dq = dqv[k];
      for (int l = 0; l < L; l++)
        dqs_edge[l] = (n_e[l] > 0) && (k >= s_t[l]) && (k < s_t[l] + n_e[l]);
      if (interfere && k == 2) begin
        rd_cmd = 1'b1; cas_whole = 3'($urandom_range(0, 7));
        fifo_dly = 2'($urandom_range(0, 3)); cas_half = ~cas_half;
      end else rd_cmd = 1'b0;
      @(posedge clk); @(negedge clk);
      if (k < r && (out_valid !== 1'b0 || busy !== 1'b1)) quiet = 1'b0;
    end
    dqs_edge = '0; rd_cmd = 1'b0;
    check(interfere ? "R3 no early pulse with mid-burst command" : "R7 no early pulse",
          DW'(quiet), DW'(1));
    check("R7 valid after tick R", DW'(out_valid), DW'(1));
    check("R2 busy low at read-out", DW'(busy), DW'(0));
    check("R6 R8 burst data", out_data, exp_data(r));
    check("R4 R5 lane error flags", DW'(out_err), DW'(exp_err(t)));
    @(posedge clk); @(negedge clk);
    check("R7 single-cycle valid", DW'(out_valid), DW'(0));
    check("R9 flags cleared", DW'(out_err), DW'(0));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy reset", DW'(busy), DW'(0));
    check("R1 valid reset", DW'(out_valid), DW'(0));
    check("R1 err reset", DW'(out_err), DW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    burst(2, 0, 1, 1, 0);   // R4 all lanes open
    burst(2, 1, 1, 2, 0);   // R4 half-cycle, late edge of window
    burst(3, 0, 2, 3, 0);   // R5 early and late lanes
    burst(1, 1, 1, 4, 0);   // R5 silent lane
    burst(2, 0, 1, 5, 0);   // R6 extra edges
    burst(3, 1, 3, 1, 1);   // R3 interference
    burst(4, 0, 2, 0, 1);   // R3 interference with random lanes
    for (int i = 0; i < 45; i++) begin
      burst(int'($urandom_range(1, 6)), int'($urandom_range(0, 1)),
            int'($urandom_range(1, 3)), 0, 1'($urandom_range(0, 1)));
      repeat (int'($urandom_range(0, 2))) @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule